// File: doc/BRIEF.md
# Cache Line Coherence State Controller

This block tracks the coherence state and the tag of every line of a small direct-mapped cache. Each line holds one of five states: Invalid, Clean, Clean/Shared, Dirty, or Dirty/Shared. Dirty/Shared is read-only, but it still owes memory a writeback.

Three agents change that state:
- The system sends probes, which look up a line by index and tag and apply a next-state command when they hit.
- The system sends data-control responses to fills and change-to-dirty requests. These set the line state directly.
- The local cache evicts lines. An eviction invalidates the line and requests a writeback when the line was dirty.

The controller also raises two pulses. One selects the all-ones fill pattern after an error fill. The other fails a pending store-conditional.

All results are registered. When a probe, a response and an eviction hit the same line in the same cycle, they take effect in a fixed order.

Top module: `coh_state_ctrl`

## Requirements
- R1: After reset every line is Invalid with tag 0, all outputs are 0, and a probe of any line reports a miss.
- R2: One cycle after `probe_valid_i` the block raises `probe_rsp_valid_o`. `probe_hit_o` is 1 only if the line is not Invalid and its tag equals `probe_tag_i`. `probe_state_o` gives the state before the probe, or Invalid (0) on a miss. A miss changes nothing. State codes are Invalid=0, Clean=1, Clean/Shared=2, Dirty=3, Dirty/Shared=4.
- R3: Probe command 0 (keep) leaves a hit line's state unchanged. So do the unused probe codes 5, 6 and 7.
- R4: Probe command 1 forces a hit line to Clean, and command 2 forces it to Clean/Shared, whatever its previous state.
- R5: Probe command 3 sends a hit Clean or Clean/Shared line to Clean/Shared. It sends a hit Dirty or Dirty/Shared line to Dirty/Shared.
- R6: Probe command 4 sends a hit Clean or Dirty/Shared line to Clean/Shared, and a hit Dirty line to Invalid.
- R7: Fill response codes 0, 1, 2 and 3 write `resp_tag_i` into the line. They set its state to Clean, Dirty, Clean/Shared and Dirty/Shared respectively.
- R8: Response code 4 (error fill) writes the tag, sets the line Invalid, and pulses `fill_ones_o` in the next cycle.
- R9: Response code 5 sets the line Dirty whatever its previous state. Code 6 leaves the line untouched and pulses `stc_fail_o` in the next cycle. Code 7 has no effect.
- R10: An eviction sets the line Invalid. In the next cycle `wb_req_o` pulses with `wb_index_o` equal to the line index, but only if the line was Dirty or Dirty/Shared.
- R11: When several operations target one index in the same cycle, the probe applies first, then the eviction, then the response. The writeback decision sees the state left by the probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_valid_i | input | 1 | Probe strobe |
| probe_index_i | input | IDX_W | Probed line |
| probe_tag_i | input | TAG_W | Probe tag |
| probe_cmd_i | input | 3 | Probe next-state command |
| resp_valid_i | input | 1 | Response strobe |
| resp_index_i | input | IDX_W | Responded line |
| resp_tag_i | input | TAG_W | Tag written by fills |
| resp_code_i | input | 3 | Response code |
| evict_valid_i | input | 1 | Eviction strobe |
| evict_index_i | input | IDX_W | Evicted line |
| probe_rsp_valid_o | output | 1 | Probe result valid |
| probe_hit_o | output | 1 | Probe hit |
| probe_state_o | output | 3 | State before the probe |
| wb_req_o | output | 1 | Writeback request |
| wb_index_o | output | IDX_W | Line to write back |
| fill_ones_o | output | 1 | Use all-ones fill data |
| stc_fail_o | output | 1 | Fail pending store-conditional |

## Verification
Every output is due exactly one clock edge after the stimulus cycle that causes it. Line state becomes visible one edge after it is written, through a keep probe whose report comes one edge after that.

The bench drives each stimulus for one cycle starting at a falling edge. It samples all outputs at the next falling edge, then reads any line state back with a separate keep probe. Same-cycle collisions are checked both through the writeback output of that cycle and through a later readback of the merged state.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_CLN = 3'd1,
    ST_CSH = 3'd2,
    ST_DRT = 3'd3,
    ST_DSH = 3'd4
  } line_state_e;

  // probe next-state commands
  localparam logic [2:0] PRB_KEEP  = 3'd0;
  localparam logic [2:0] PRB_CLEAN = 3'd1;
  localparam logic [2:0] PRB_SHARE = 3'd2;
  localparam logic [2:0] PRB_DBIT  = 3'd3;
  localparam logic [2:0] PRB_EXCL  = 3'd4;

  // data-control responses
  localparam logic [2:0] RSP_FILL_CLN = 3'd0;
  localparam logic [2:0] RSP_FILL_DRT = 3'd1;
  localparam logic [2:0] RSP_FILL_CSH = 3'd2;
  localparam logic [2:0] RSP_FILL_DSH = 3'd3;
  localparam logic [2:0] RSP_FILL_ERR = 3'd4;
  localparam logic [2:0] RSP_CTD_OK   = 3'd5;
  localparam logic [2:0] RSP_CTD_FAIL = 3'd6;

  function automatic logic is_dirty(line_state_e s);
    return (s == ST_DRT) || (s == ST_DSH);
  endfunction

endpackage

// File: rtl/coh_probe_next.sv
module coh_probe_next
  import coh_pkg::*;
(
  input  line_state_e cur_i,
  input  logic [2:0]  cmd_i,
  output line_state_e nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    unique case (cmd_i)
      PRB_CLEAN: nxt_o = ST_CLN;
      PRB_SHARE: nxt_o = ST_CSH;
      PRB_DBIT:  nxt_o = is_dirty(cur_i) ? ST_DSH : ST_CSH;
      PRB_EXCL:  nxt_o = (cur_i == ST_DRT) ? ST_INV : ST_CSH;
      default:   nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/coh_resp_decode.sv
module coh_resp_decode
  import coh_pkg::*;
(
  input  logic        valid_i,
  input  logic [2:0]  code_i,
  output logic        state_we_o,
  output logic        tag_we_o,
  output line_state_e state_o,
  output logic        fill_ones_o,
  output logic        stc_fail_o
);

  always_comb begin
    state_we_o  = 1'b0;
    tag_we_o    = 1'b0;
    state_o     = ST_INV;
    fill_ones_o = 1'b0;
    stc_fail_o  = 1'b0;
    if (valid_i) begin
      unique case (code_i)
        RSP_FILL_CLN: begin state_we_o = 1'b1; tag_we_o = 1'b1; state_o = ST_CLN; end
        RSP_FILL_DRT: begin state_we_o = 1'b1; tag_we_o = 1'b1; state_o = ST_DRT; end
        RSP_FILL_CSH: begin state_we_o = 1'b1; tag_we_o = 1'b1; state_o = ST_CSH; end
        RSP_FILL_DSH: begin state_we_o = 1'b1; tag_we_o = 1'b1; state_o = ST_DSH; end
        RSP_FILL_ERR: begin
          state_we_o  = 1'b1;
          tag_we_o    = 1'b1;
          state_o     = ST_INV;
          fill_ones_o = 1'b1;
        end
        RSP_CTD_OK:   begin state_we_o = 1'b1; state_o = ST_DRT; end
        RSP_CTD_FAIL: stc_fail_o = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_line.sv
module coh_line
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             probe_we_i,
  input  line_state_e      probe_state_i,
  input  logic             evict_we_i,
  input  logic             resp_we_i,
  input  logic             resp_tag_we_i,
  input  line_state_e      resp_state_i,
  input  logic [TAG_W-1:0] resp_tag_i,
  output line_state_e      state_o,
  output logic [TAG_W-1:0] tag_o,
  output line_state_e      post_probe_o
);

  line_state_e      state_q, state_d, after_evict;
  logic [TAG_W-1:0] tag_q;

  // order: probe, then eviction, then response
  always_comb begin
    post_probe_o = probe_we_i ? probe_state_i : state_q;
    after_evict  = evict_we_i ? ST_INV : post_probe_o;
    state_d      = resp_we_i ? resp_state_i : after_evict;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INV;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (resp_tag_we_i) tag_q <= resp_tag_i;
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;

  p_evict_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_we_i && !resp_we_i |=> state_q == ST_INV);

  p_resp_last_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_we_i |=> state_q == $past(resp_state_i));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe_we_i && !evict_we_i && !resp_we_i && !resp_tag_we_i
      |=> $stable(state_q) && $stable(tag_q));

endmodule

// File: rtl/coh_state_ctrl.sv
module coh_state_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             probe_valid_i,
  input  logic [IDX_W-1:0] probe_index_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  input  logic [2:0]       probe_cmd_i,
  input  logic             resp_valid_i,
  input  logic [IDX_W-1:0] resp_index_i,
  input  logic [TAG_W-1:0] resp_tag_i,
  input  logic [2:0]       resp_code_i,
  input  logic             evict_valid_i,
  input  logic [IDX_W-1:0] evict_index_i,
  output logic             probe_rsp_valid_o,
  output logic             probe_hit_o,
  output logic [2:0]       probe_state_o,
  output logic             wb_req_o,
  output logic [IDX_W-1:0] wb_index_o,
  output logic             fill_ones_o,
  output logic             stc_fail_o
);

  logic [NUM_LINES-1:0][2:0]       line_st;
  logic [NUM_LINES-1:0][2:0]       line_post;
  logic [NUM_LINES-1:0][TAG_W-1:0] line_tag;

  line_state_e prb_cur, prb_nxt, rsp_state, ev_state;
  logic        prb_hit;
  logic        rsp_state_we, rsp_tag_we, rsp_ones, rsp_fail;

  assign prb_cur = line_state_e'(line_st[probe_index_i]);
  assign prb_hit = probe_valid_i && (prb_cur != ST_INV)
                   && (line_tag[probe_index_i] == probe_tag_i);
  assign ev_state = line_state_e'(line_post[evict_index_i]);

  coh_probe_next u_probe_next (
    .cur_i (prb_cur),
    .cmd_i (probe_cmd_i),
    .nxt_o (prb_nxt)
  );

  coh_resp_decode u_resp_decode (
    .valid_i     (resp_valid_i),
    .code_i      (resp_code_i),
    .state_we_o  (rsp_state_we),
    .tag_we_o    (rsp_tag_we),
    .state_o     (rsp_state),
    .fill_ones_o (rsp_ones),
    .stc_fail_o  (rsp_fail)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic        sel_p, sel_e, sel_r;
    line_state_e st, post;

    assign sel_p = prb_hit && (probe_index_i == IDX_W'(i));
    assign sel_e = evict_valid_i && (evict_index_i == IDX_W'(i));
    assign sel_r = resp_index_i == IDX_W'(i);

    coh_line #(.TAG_W(TAG_W)) u_line (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .probe_we_i    (sel_p),
      .probe_state_i (prb_nxt),
      .evict_we_i    (sel_e),
      .resp_we_i     (sel_r && rsp_state_we),
      .resp_tag_we_i (sel_r && rsp_tag_we),
      .resp_state_i  (rsp_state),
      .resp_tag_i    (resp_tag_i),
      .state_o       (st),
      .tag_o         (line_tag[i]),
      .post_probe_o  (post)
    );

    assign line_st[i]   = st;
    assign line_post[i] = post;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_rsp_valid_o <= 1'b0;
      probe_hit_o       <= 1'b0;
      probe_state_o     <= ST_INV;
      wb_req_o          <= 1'b0;
      wb_index_o        <= '0;
      fill_ones_o       <= 1'b0;
      stc_fail_o        <= 1'b0;
    end else begin
      probe_rsp_valid_o <= probe_valid_i;
      probe_hit_o       <= prb_hit;
      probe_state_o     <= prb_hit ? prb_cur : ST_INV;
      wb_req_o          <= evict_valid_i && is_dirty(ev_state);
      if (evict_valid_i) wb_index_o <= evict_index_i;
      fill_ones_o       <= rsp_ones;
      stc_fail_o        <= rsp_fail;
    end
  end

  p_probe_answer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_valid_i |=> probe_rsp_valid_o);

  p_miss_reports_inv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_rsp_valid_o && !probe_hit_o |-> probe_state_o == 3'd0);

  p_wb_after_evict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> $past(evict_valid_i) && wb_index_o == $past(evict_index_i));

  p_fail_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stc_fail_o |-> $past(resp_valid_i) && $past(resp_code_i) == RSP_CTD_FAIL);

  p_ones_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ones_o |-> $past(resp_valid_i) && $past(resp_code_i) == RSP_FILL_ERR);

endmodule

// File: tb/coh_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_state_ctrl_tb_top;

  localparam int OP_P = 0;
  localparam int OP_R = 1;
  localparam int OP_E = 2;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] idx;
    logic [7:0] tag;
    logic [2:0] code;
    logic       hit;
    logic [2:0] st;
    logic       wb;
    logic       fail;
    logic       ones;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd3,  8'h5A, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 fill clean
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 keep
    '{2'd0, 4'd3,  8'h11, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 tag miss
    '{2'd0, 4'd3,  8'h5A, 3'd3, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 clean -> C/S
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd5},
    '{2'd2, 4'd3,  8'h00, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 no wb
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd10},
    '{2'd1, 4'd3,  8'h5A, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd3,  8'h5A, 3'd3, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 dirty -> D/S
    '{2'd0, 4'd3,  8'h5A, 3'd3, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 4'd5},
    '{2'd0, 4'd3,  8'h5A, 3'd4, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 D/S -> C/S
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd6},
    '{2'd1, 4'd3,  8'h5A, 3'd5, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 ctd ok
    '{2'd0, 4'd3,  8'h5A, 3'd4, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 dirty -> inv
    '{2'd0, 4'd3,  8'h5A, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd6},
    '{2'd1, 4'd5,  8'h22, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd5,  8'h22, 3'd0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd2, 4'd5,  8'h00, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 wb D/S
    '{2'd1, 4'd6,  8'h33, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd1, 4'd6,  8'h33, 3'd6, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 ctd fail
    '{2'd0, 4'd6,  8'h33, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd9},
    '{2'd1, 4'd6,  8'h33, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 error fill
    '{2'd0, 4'd6,  8'h33, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{2'd1, 4'd7,  8'h44, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd7,  8'h44, 3'd2, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 force C/S
    '{2'd0, 4'd7,  8'h44, 3'd1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 force clean
    '{2'd0, 4'd7,  8'h44, 3'd5, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 unused code
    '{2'd0, 4'd7,  8'h44, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd3},
    '{2'd1, 4'd7,  8'h44, 3'd7, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 code 7
    '{2'd0, 4'd7,  8'h44, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd9},
    '{2'd1, 4'd8,  8'h55, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd8,  8'h55, 3'd1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 dirty -> clean
    '{2'd2, 4'd8,  8'h00, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd10},
    '{2'd1, 4'd9,  8'h66, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd0, 4'd9,  8'h66, 3'd4, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 clean -> C/S
    '{2'd0, 4'd9,  8'h66, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd6},
    '{2'd1, 4'd10, 8'h77, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{2'd1, 4'd10, 8'h77, 3'd5, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd9},
    '{2'd2, 4'd10, 8'h00, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 wb dirty
    '{2'd1, 4'd2,  8'h88, 3'd6, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd9},
    '{2'd0, 4'd2,  8'h88, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pv = 1'b0, rv = 1'b0, ev = 1'b0;
  logic [3:0] pi = '0, ri = '0, ei = '0;
  logic [7:0] pt = '0, rt = '0;
  logic [2:0] pc = '0, rc = '0;
  logic       rsp_v, hit, wb, ones, fail;
  logic [2:0] pst;
  logic [3:0] wbi;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  coh_state_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .probe_valid_i (pv), .probe_index_i (pi), .probe_tag_i (pt), .probe_cmd_i (pc),
    .resp_valid_i (rv), .resp_index_i (ri), .resp_tag_i (rt), .resp_code_i (rc),
    .evict_valid_i (ev), .evict_index_i (ei),
    .probe_rsp_valid_o (rsp_v), .probe_hit_o (hit), .probe_state_o (pst),
    .wb_req_o (wb), .wb_index_o (wbi), .fill_ones_o (ones), .stc_fail_o (fail)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs held from one falling edge to the next; outputs then sampled
  task automatic cycle();
    @(negedge clk);
    pv = 1'b0; rv = 1'b0; ev = 1'b0;
  endtask

  task automatic set_probe(input logic [3:0] i, input logic [7:0] t, input logic [2:0] c);
    pv = 1'b1; pi = i; pt = t; pc = c;
  endtask

  task automatic set_resp(input logic [3:0] i, input logic [7:0] t, input logic [2:0] c);
    rv = 1'b1; ri = i; rt = t; rc = c;
  endtask

  task automatic set_evict(input logic [3:0] i);
    ev = 1'b1; ei = i;
  endtask

  task automatic expect_probe(input string req, input logic [3:0] i, input logic [7:0] t,
                              input logic e_hit, input logic [2:0] e_st);
    set_probe(i, t, 3'd0);
    cycle();
    check(req, "probe_hit", int'(hit), int'(e_hit));
    check(req, "probe_state", int'(pst), int'(e_st));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "rsp_valid", int'(rsp_v), 0);
    check("R1", "wb_req", int'(wb), 0);
    check("R1", "fill_ones", int'(ones), 0);
    check("R1", "stc_fail", int'(fail), 0);
    for (int i = 0; i < 16; i++) expect_probe("R1", 4'(i), 8'h00, 1'b0, 3'd0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      rq = $sformatf("R%0d", v.req);
      case (int'(v.op))
        OP_P: set_probe(v.idx, v.tag, v.code);
        OP_R: set_resp(v.idx, v.tag, v.code);
        default: set_evict(v.idx);
      endcase
      cycle();
      check(rq, "wb_req", int'(wb), int'(v.wb));
      check(rq, "stc_fail", int'(fail), int'(v.fail));
      check(rq, "fill_ones", int'(ones), int'(v.ones));
      check(rq, "rsp_valid", int'(rsp_v), int'(v.op == 2'(OP_P)));
      if (int'(v.op) == OP_P) begin
        check(rq, "probe_hit", int'(hit), int'(v.hit));
        check(rq, "probe_state", int'(pst), int'(v.st));
      end
      if (v.wb) check(rq, "wb_index", int'(wbi), int'(v.idx));
    end

    // R11 probe T3 on Dirty, then C/S fill in same cycle
    set_resp(4'd11, 8'hAB, 3'd1);
    cycle();
    set_probe(4'd11, 8'hAB, 3'd4);
    set_resp(4'd11, 8'hAB, 3'd2);
    cycle();
    check("R11", "probe_hit", int'(hit), 1);
    check("R11", "probe_state", int'(pst), 3);
    expect_probe("R11", 4'd11, 8'hAB, 1'b1, 3'd2);

    // R11 probe to Clean before eviction: no writeback
    set_resp(4'd12, 8'hCD, 3'd1);
    cycle();
    set_probe(4'd12, 8'hCD, 3'd1);
    set_evict(4'd12);
    cycle();
    check("R11", "wb_req", int'(wb), 0);
    check("R11", "probe_state", int'(pst), 3);
    expect_probe("R11", 4'd12, 8'hCD, 1'b0, 3'd0);

    // R11 eviction then fill on the same line
    set_resp(4'd13, 8'hEF, 3'd0);
    cycle();
    set_evict(4'd13);
    set_resp(4'd13, 8'hEF, 3'd3);
    cycle();
    check("R11", "wb_req", int'(wb), 0);
    expect_probe("R11", 4'd13, 8'hEF, 1'b1, 3'd4);
    set_evict(4'd13);
    cycle();
    check("R10", "wb_req", int'(wb), 1);
    check("R10", "wb_index", int'(wbi), 13);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule